// File: doc/BRIEF.md
# Periodic Interrupt Request Generator

This block produces a single interrupt request for a timekeeping core. The request is an enable for an external pull-down transistor (1 = pull the line low). A 4-bit cycle code picks the source. With the top code bit clear, the block runs in pulse mode and emits fixed waveforms derived from a sub-second phase counter. With the top code bit set, it runs in level mode: a chosen calendar rollover event sets a sticky flag, and the flag holds the line low until software clears it. The flag is readable. In pulse mode it simply reports the line state.

The phase counter advances on a strobe supplied by the clock prescaler at 2**PHASE_W ticks per second (2048 Hz by default; PHASE_W must be at least 11). The calendar supplies one strobe per rollover event. The weekly strobe is expected at day-of-week 0, midnight, and the monthly strobe on day 1, midnight. A watchdog on the host chip-enable input detects an enable that has been held high too long. It then overrides every mode with a 1 Hz square wave, so the oscillator can be measured.

Top module: `tick_irq_gen`

## Requirements
- R1: While reset is asserted, and right after it, irq_pull_o and flag_o are 0, the cycle code is 0000 and the phase counter is 0.
- R2: Pulse code 0000 keeps irq_pull_o at 0 and code 0001 keeps it at 1. The cycle code applies to irq_pull_o one clock after the register that holds it is updated.
- R3: Pulse code 0010 gives a 50% duty 1024 Hz square wave. irq_pull_o equals bit PHASE_W-11 of the phase counter, seen one clock later, so it toggles on every sub-tick.
- R4: Pulse code 0011 asserts irq_pull_o for exactly one sub-tick interval (1/2048 s) out of every 1024 sub-ticks. This happens when phase bits PHASE_W-2 down to PHASE_W-11 are all zero.
- R5: In pulse mode, flag_o equals irq_pull_o and flag writes have no effect.
- R6: In level mode (code 1sss), only roll_i[sss] can set the flag. Bit k means 0: 1 s, 1: 10 s, 2: 1 min, 3: 10 min, 4: 1 h, 5: 1 day, 6: 1 week, 7: 1 month. In level mode irq_pull_o follows the flag one clock later.
- R7: The level flag stays set until a flag write of 0. A flag write of 1 sets it. A flag write takes precedence over an event in the same cycle.
- R8: Any cycle-code write clears the level flag.
- R9: When ce_i has been high for 5120 sub-ticks (2.5 s), irq_pull_o follows the phase counter MSB (a 1 Hz square wave) in every mode. A high time of 3072 sub-ticks (1.5 s) has no effect.
- R10: ce_i low clears the hold timer and ends the override in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sub_tick_i | input | 1 | Prescaler strobe, 2**PHASE_W per second |
| roll_i | input | 8 | Rollover event strobes, bit k = level-mode selector k |
| ct_we_i | input | 1 | Cycle code write strobe |
| ct_wdata_i | input | 4 | Cycle code write data |
| flag_we_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write data |
| ce_i | input | 1 | Host chip enable (high = access in progress) |
| irq_pull_o | output | 1 | 1 = drive the interrupt line low |
| flag_o | output | 1 | Flag readback |

## Verification
An incorrect phase count shows up at irq_pull_o as a shifted or wrongly timed edge. Under codes 0010 and 0011 this appears within one sub-tick, and under the override within half a second. A level flag left set, or one that fails to set, shows on flag_o in the same cycle and on irq_pull_o one clock later. A hold timer that runs past its limit or misses it changes the line after 1.5 s of enable, or fails to change it after 2.5 s. A reference model in the bench is compared against both outputs on every cycle, so each of these faults is caught within a cycle of reaching the ports.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

  localparam int unsigned NUM_EVT = 8;
  localparam int unsigned CODE_W  = 4;

  typedef enum logic [1:0] {
    PM_OFF   = 2'b00,
    PM_HOLD  = 2'b01,
    PM_SQ    = 2'b10,
    PM_BURST = 2'b11
  } pulse_sel_e;

  typedef struct packed {
    logic       lvl_mode;
    logic [2:0] sel;
  } cycle_code_t;

endpackage

// File: rtl/irq_phase_ctr.sv
module irq_phase_ctr #(
  parameter int unsigned PHASE_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sub_tick_i,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] ph_q;
  logic [PHASE_W-1:0] ph_d;

  always_comb begin
    ph_d = ph_q;
    if (sub_tick_i) begin
      ph_d = ph_q + PHASE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign phase_o = ph_q;

endmodule

// File: rtl/irq_force_timer.sv
module irq_force_timer #(
  parameter int unsigned LIMIT = 5120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_i,
  input  logic sub_tick_i,
  output logic force_o
);

  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = ce_i && sub_tick_i && (cnt_q != CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (!ce_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign force_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/irq_level_flag.sv
module irq_level_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic code_we_i,
  input  logic lvl_mode_i,
  input  logic flag_we_i,
  input  logic flag_wdata_i,
  input  logic evt_hit_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (code_we_i) begin
      flag_d = 1'b0;
    end else if (lvl_mode_i && flag_we_i) begin
      flag_d = flag_wdata_i;
    end else if (lvl_mode_i && evt_hit_i) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen
  import tick_irq_pkg::*;
#(
  parameter int unsigned PHASE_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sub_tick_i,
  input  logic [NUM_EVT-1:0] roll_i,
  input  logic               ct_we_i,
  input  logic [CODE_W-1:0]  ct_wdata_i,
  input  logic               flag_we_i,
  input  logic               flag_wdata_i,
  input  logic               ce_i,
  output logic               irq_pull_o,
  output logic               flag_o
);

  localparam int unsigned SQ_BIT    = PHASE_W - 11;
  localparam int unsigned BURST_HI  = PHASE_W - 2;
  localparam int unsigned BURST_LO  = PHASE_W - 11;
  localparam int unsigned MSB_BIT   = PHASE_W - 1;
  localparam int unsigned HOLD_LIM  = 5 * (2 ** (PHASE_W - 1));

  cycle_code_t        ct_q;
  cycle_code_t        ct_d;
  logic [PHASE_W-1:0] ph_q;
  logic               force_on;
  logic               lvl_q;
  logic               evt_hit;
  logic               pulse_lvl;
  logic               irq_d;
  logic               irq_q;
  pulse_sel_e         psel;

  always_comb begin
    ct_d = ct_q;
    if (ct_we_i) begin
      ct_d = cycle_code_t'(ct_wdata_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ct_q <= '0;
    end else begin
      ct_q <= ct_d;
    end
  end

  irq_phase_ctr #(
    .PHASE_W (PHASE_W)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .sub_tick_i (sub_tick_i),
    .phase_o    (ph_q)
  );

  irq_force_timer #(
    .LIMIT (HOLD_LIM)
  ) u_force (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_i       (ce_i),
    .sub_tick_i (sub_tick_i),
    .force_o    (force_on)
  );

  assign evt_hit = roll_i[ct_q.sel];

  irq_level_flag u_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .code_we_i    (ct_we_i),
    .lvl_mode_i   (ct_q.lvl_mode),
    .flag_we_i    (flag_we_i),
    .flag_wdata_i (flag_wdata_i),
    .evt_hit_i    (evt_hit),
    .flag_o       (lvl_q)
  );

  assign psel = pulse_sel_e'(ct_q.sel[1:0]);

  always_comb begin
    unique case (psel)
      PM_OFF:   pulse_lvl = 1'b0;
      PM_HOLD:  pulse_lvl = 1'b1;
      PM_SQ:    pulse_lvl = ph_q[SQ_BIT];
      PM_BURST: pulse_lvl = (ph_q[BURST_HI:BURST_LO] == '0);
      default:  pulse_lvl = 1'b0;
    endcase
  end

  always_comb begin
    if (force_on) begin
      irq_d = ph_q[MSB_BIT];
    end else if (ct_q.lvl_mode) begin
      irq_d = lvl_q;
    end else begin
      irq_d = pulse_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_pull_o = irq_q;
  assign flag_o     = ct_q.lvl_mode ? lvl_q : irq_q;

endmodule

// File: rtl/tick_irq_gen_chk.sv
module tick_irq_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_i,
  input logic       ct_we_i,
  input logic       flag_we_i,
  input logic       irq_pull_o,
  input logic [3:0] ct_q,
  input logic       lvl_q,
  input logic       force_on,
  input logic       ph_msb
);

  p_off_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_q == 4'b0000 && !force_on) |=> !irq_pull_o);

  p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_q == 4'b0001 && !force_on) |=> irq_pull_o);

  p_pulse_noflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ct_q[3] |=> !lvl_q);

  p_level_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_q[3] && !force_on) |=> (irq_pull_o == $past(lvl_q)));

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q && !flag_we_i && !ct_we_i) |=> lvl_q);

  p_code_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ct_we_i |=> !lvl_q);

  p_force_square_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |=> (irq_pull_o == $past(ph_msb)));

  p_ce_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> !force_on);

endmodule

bind tick_irq_gen tick_irq_gen_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_i       (ce_i),
  .ct_we_i    (ct_we_i),
  .flag_we_i  (flag_we_i),
  .irq_pull_o (irq_pull_o),
  .ct_q       (ct_q),
  .lvl_q      (lvl_q),
  .force_on   (force_on),
  .ph_msb     (ph_q[PHASE_W-1])
);

// File: tb/tick_irq_gen_tb_top.sv
`timescale 1ns/1ps
module tick_irq_gen_tb_top;

  localparam int PH_MOD   = 2048;
  localparam int HOLD_LIM = 5120;

  logic       clk;
  logic       rst_n;
  logic       sub_tick;
  logic [7:0] roll;
  logic       ct_we;
  logic [3:0] ct_wdata;
  logic       flag_we;
  logic       flag_wdata;
  logic       ce;
  logic       irq_pull;
  logic       flag;

  int n_vec;
  int n_bad;
  bit done;

  tick_irq_gen dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sub_tick_i   (sub_tick),
    .roll_i       (roll),
    .ct_we_i      (ct_we),
    .ct_wdata_i   (ct_wdata),
    .flag_we_i    (flag_we),
    .flag_wdata_i (flag_wdata),
    .ce_i         (ce),
    .irq_pull_o   (irq_pull),
    .flag_o       (flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model state
  int       m_ph;
  logic [3:0] m_ct;
  bit       m_lvl;
  int       m_cnt;
  bit       m_irq;

  function automatic bit f_pull(int ph, logic [3:0] ct, bit lvl, int cnt);
    if (cnt >= HOLD_LIM) return bit'((ph >> 10) & 1);
    if (ct[3]) return lvl;
    case (ct[1:0])
      2'b00:   return 1'b0;
      2'b01:   return 1'b1;
      2'b10:   return bit'(ph & 1);
      default: return ((ph % 1024) == 0);
    endcase
  endfunction

  function automatic bit f_flag(logic [3:0] ct, bit lvl, bit irq);
    return ct[3] ? lvl : irq;
  endfunction

  function automatic string f_tag(logic [3:0] ct, int cnt);
    if (cnt >= HOLD_LIM) return "R9";
    if (ct[3]) return "R6/R7";
    case (ct[1:0])
      2'b10:   return "R3";
      2'b11:   return "R4";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_ct = 4'b0000; m_lvl = 1'b0; m_cnt = 0; m_irq = 1'b0;
    end else begin
      m_irq = f_pull(m_ph, m_ct, m_lvl, m_cnt);
      if (sub_tick) m_ph = (m_ph + 1) % PH_MOD;
      if (ct_we) m_lvl = 1'b0;
      else if (m_ct[3] && flag_we) m_lvl = flag_wdata;
      else if (m_ct[3] && roll[m_ct[2:0]]) m_lvl = 1'b1;
      if (ct_we) m_ct = ct_wdata;
      if (!ce) m_cnt = 0;
      else if (sub_tick && m_cnt < HOLD_LIM) m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(string tag, bit got, bit exp, string what);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // advance to the next negedge and compare against the model
  task automatic cyc();
    @(negedge clk);
    chk(f_tag(m_ct, m_cnt), irq_pull, m_irq, "irq_pull model");
    chk(f_tag(m_ct, m_cnt), flag, f_flag(m_ct, m_lvl, m_irq), "flag model");
  endtask

  task automatic idle();
    roll = '0; ct_we = 1'b0; flag_we = 1'b0;
  endtask

  task automatic wr_code(logic [3:0] v);
    ct_we = 1'b1; ct_wdata = v; cyc(); ct_we = 1'b0;
  endtask

  task automatic wr_flag(bit v);
    flag_we = 1'b1; flag_wdata = v; cyc(); flag_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    int seed;
    int cnt1;
    bit prev;
    n_vec = 0; n_bad = 0; done = 1'b0;
    seed = $urandom(32'h5eed_1234);
    rst_n = 1'b0; sub_tick = 1'b0; ce = 1'b0; ct_wdata = '0; flag_wdata = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    chk("R1", irq_pull, 1'b0, "pull in reset");
    chk("R1", flag, 1'b0, "flag in reset");
    rst_n = 1'b1;
    cyc();
    chk("R1", irq_pull, 1'b0, "pull after reset");

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      sub_tick = ($urandom % 2) == 0;
      roll = (($urandom % 16) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      ct_we = ($urandom % 64) == 0;
      ct_wdata = 4'($urandom);
      flag_we = ($urandom % 32) == 0;
      flag_wdata = 1'($urandom);
      if (($urandom % 200) == 0) ce = ~ce;
      cyc();
    end
    idle(); ce = 1'b0; sub_tick = 1'b0;
    cyc(); cyc();

    // R2 off and hold
    wr_code(4'b0000); cyc();
    chk("R2", irq_pull, 1'b0, "code 0000 released");
    wr_code(4'b0001); cyc();
    chk("R2", irq_pull, 1'b1, "code 0001 held");

    // R5 flag write ignored in pulse mode
    wr_flag(1'b0); cyc();
    chk("R5", flag, 1'b1, "flag mirrors pull after write 0");
    wr_code(4'b0000); cyc();
    wr_flag(1'b1); cyc();
    chk("R5", flag, 1'b0, "flag ignores write 1");
    chk("R5", irq_pull, 1'b0, "pull ignores flag write");

    // R3 square wave
    sub_tick = 1'b1;
    wr_code(4'b0010); cyc(); cyc();
    prev = irq_pull;
    for (int i = 0; i < 8; i++) begin
      cyc();
      chk("R3", irq_pull, ~prev, "1024 Hz toggle");
      prev = irq_pull;
    end

    // R4 short burst
    wr_code(4'b0011); cyc();
    cnt1 = 0;
    for (int i = 0; i < 2048; i++) begin
      cyc();
      if (irq_pull) cnt1++;
    end
    chk("R4", cnt1 == 2, 1'b1, "two burst cycles per 2048 ticks");
    sub_tick = 1'b0;

    // R6 / R7 level mode, minute event (code 1010)
    wr_code(4'b1010); cyc();
    roll = 8'b0000_0001; cyc(); roll = '0; cyc(); cyc();
    chk("R6", flag, 1'b0, "unselected event ignored");
    chk("R6", irq_pull, 1'b0, "unselected event no pull");
    roll = 8'b0000_0100; cyc(); roll = '0;
    chk("R6", flag, 1'b1, "selected event sets flag");
    cyc();
    chk("R6", irq_pull, 1'b1, "pull follows flag");
    repeat (40) cyc();
    chk("R7", flag, 1'b1, "flag held");
    chk("R7", irq_pull, 1'b1, "pull held");
    wr_flag(1'b0);
    chk("R7", flag, 1'b0, "write 0 clears");
    cyc();
    chk("R7", irq_pull, 1'b0, "pull released");
    wr_flag(1'b1);
    chk("R7", flag, 1'b1, "write 1 sets");
    roll = 8'b0000_0100; flag_we = 1'b1; flag_wdata = 1'b0; cyc(); idle();
    chk("R7", flag, 1'b0, "write beats event");

    // R8 code write clears pending flag
    wr_flag(1'b1);
    wr_code(4'b1010);
    chk("R8", flag, 1'b0, "code write clears flag");
    cyc();
    chk("R8", irq_pull, 1'b0, "pull released after code write");

    // R9 / R10 forced 1 Hz
    wr_code(4'b0000); cyc();
    sub_tick = 1'b1; ce = 1'b1;
    repeat (3072) cyc();
    chk("R9", irq_pull, 1'b0, "1.5 s hold no output");
    repeat (HOLD_LIM - 3072 + 2) cyc();
    cnt1 = 0;
    for (int i = 0; i < 2048; i++) begin
      cyc();
      if (irq_pull) cnt1++;
    end
    chk("R9", cnt1 == 1024, 1'b1, "1 Hz square after 2.5 s");
    ce = 1'b0; cyc(); cyc();
    chk("R10", irq_pull, 1'b0, "override ends on ce low");
    ce = 1'b1;
    repeat (100) cyc();
    chk("R10", irq_pull, 1'b0, "timer restarted from zero");
    ce = 1'b0; sub_tick = 1'b0;
    cyc(); cyc();

    finish_run();
  end

endmodule